// File: doc/BRIEF.md
# Float to Unsigned Integer Converter

This block turns a binary floating-point operand, either single precision (32-bit) or double precision (64-bit), into an unsigned integer of 32 or 64 bits. Two select inputs choose the operand format and the result width. A 2-bit rounding-mode input picks how discarded fraction bits are handled. The unsigned target drives the sign rules. A negative operand that would give a non-zero magnitude saturates to zero and is invalid. A negative fraction that rounds to zero under the selected mode is only inexact.

Two conditions are reported: invalid and inexact. Each has its own trap enable. When the trap for a raised condition is enabled, the block drops the result. It drives a zero result, asserts `trap_o` and gives the condition in `exc_code_o`. When the trap is disabled, the block drives the result and sets the matching flag. Invalid wins over inexact, so at most one condition is ever reported. The conversion is combinational and is captured in one output register stage, which is loaded on each `valid_i` cycle.

Top module: `fp2uint_cvt`

## Requirements
- R1: Every cycle with `valid_i` high gives `valid_o` high on the next cycle, together with that operation's result, trap and flags. A cycle with `valid_i` low gives `valid_o` low on the next cycle. Reset clears all outputs to zero.
- R2: A positive operand with an unbiased exponent from 0 up to (result width − 1) gives the integer formed by shifting the significand, with the hidden bit included, by the exponent. If no fraction bits are discarded, no flag is raised.
- R3: If fraction bits are discarded, the operation is inexact and `rmode_i` sets the rounding. Encodings: 0 is nearest-even, 1 is toward zero, 2 is toward plus infinity, 3 is toward minus infinity. Mode 2 adds one. Modes 1 and 3 truncate. Mode 0 adds one only if the round bit is set and either the sticky bit or the integer LSB is set.
- R4: A non-zero operand of magnitude below one gives 0 and is inexact, except in three cases. Mode 2 with a positive sign gives 1. Mode 0 with unbiased exponent −1, a non-zero mantissa and a positive sign gives 1. The invalid cases are listed in R5.
- R5: These negative operands give 0 and are invalid: any with unbiased exponent ≥ 0; below one under mode 3; below one under mode 0 with unbiased exponent −1 and a non-zero mantissa. A negative fraction under modes 1 or 2 is only inexact.
- R6: An unbiased exponent above (result width − 1) saturates and is invalid. A positive sign gives all ones of the result width. A negative sign gives zero.
- R7: If a rounding increment carries out of the result width, the result saturates to all ones of that width and is invalid.
- R8: An operand of zero exponent and zero mantissa, of either sign, gives 0 with no flag and no trap.
- R9: Invalid takes priority over inexact: `flag_inv_o` and `flag_inx_o` are never high together, and an invalid operation never reports inexact.
- R10: When the raised condition's trap enable is high, the block drives `trap_o`=1 and `result_o`=0, with both flags low. `exc_code_o` is 1 for invalid and 2 for inexact, and 0 when there is no trap. When the trap enable is low, the block drives the result and sets the flag.
- R11: `src_dbl_i`=0 takes a single-precision operand from `operand_i[31:0]` and ignores `operand_i[63:32]`. `dst_wide_i`=0 yields a 32-bit result, zero-extended in `result_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operand valid, loads the output stage |
| operand_i | input | 64 | Floating-point operand (single in low 32 bits) |
| src_dbl_i | input | 1 | 1: double-precision operand, 0: single |
| dst_wide_i | input | 1 | 1: 64-bit result, 0: 32-bit result |
| rmode_i | input | 2 | Rounding mode (0 near-even, 1 zero, 2 up, 3 down) |
| trap_inv_en_i | input | 1 | Trap enable for invalid |
| trap_inx_en_i | input | 1 | Trap enable for inexact |
| valid_o | output | 1 | Result valid |
| result_o | output | 64 | Unsigned integer result |
| trap_o | output | 1 | Exception raised instead of result |
| exc_code_o | output | 2 | Trapped condition: 1 invalid, 2 inexact |
| flag_inv_o | output | 1 | Invalid flag (untrapped) |
| flag_inx_o | output | 1 | Inexact flag (untrapped) |

## Verification
Every result, flag and trap output is due exactly one clock edge after the cycle in which `valid_i` is high, because only the output stage holds state. The bench applies each operand at a falling edge and lets one rising edge pass. It then samples all outputs one nanosecond later. It also checks that `valid_o` drops after the following idle edge. Expected values for each rounding mode, sign and exponent boundary are worked out by hand from the requirements and written as constants.

// File: rtl/fp2uint_pkg.sv
package fp2uint_pkg;
  localparam int OPW     = 64;
  localparam int RESW    = 64;
  localparam int NARW    = 32;
  localparam int SGL_EW  = 8;
  localparam int SGL_MW  = 23;
  localparam int DBL_EW  = 11;
  localparam int DBL_MW  = 52;
  localparam int EXPW    = 13;
  localparam int SIGW    = DBL_MW + 1;
  localparam int FRACW   = DBL_MW + RESW;
  localparam int XW      = SIGW + RESW;
  localparam int YW      = FRACW + RESW;
  localparam int SHW     = $clog2(RESW);
  localparam int SGL_BIAS = (1 << (SGL_EW - 1)) - 1;
  localparam int DBL_BIAS = (1 << (DBL_EW - 1)) - 1;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_INV  = 2'd1,
    EXC_INX  = 2'd2
  } exc_e;

  typedef struct packed {
    logic                   sign;
    logic signed [EXPW-1:0] uexp;
    logic [SIGW-1:0]        sig;
    logic                   mant_nz;
    logic                   is_zero;
  } fields_t;
endpackage

// File: rtl/fp2uint_unpack.sv
module fp2uint_unpack
  import fp2uint_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  input  logic           dbl_i,
  output fields_t        f_o
);
  localparam logic signed [EXPW-1:0] SBIAS = EXPW'(SGL_BIAS);
  localparam logic signed [EXPW-1:0] DBIAS = EXPW'(DBL_BIAS);

  logic [DBL_EW-1:0] d_exp;
  logic [DBL_MW-1:0] d_man;
  logic [SGL_EW-1:0] s_exp;
  logic [SGL_MW-1:0] s_man;

  assign d_exp = op_i[OPW-2 -: DBL_EW];
  assign d_man = op_i[DBL_MW-1:0];
  assign s_exp = op_i[NARW-2 -: SGL_EW];
  assign s_man = op_i[SGL_MW-1:0];

  always_comb begin
    if (dbl_i) begin
      f_o.sign    = op_i[OPW-1];
      f_o.uexp    = $signed({{(EXPW-DBL_EW){1'b0}}, d_exp}) - DBIAS;
      f_o.sig     = {1'b1, d_man};
      f_o.mant_nz = |d_man;
      f_o.is_zero = (d_exp == '0) && (d_man == '0);
    end else begin
      f_o.sign    = op_i[NARW-1];
      f_o.uexp    = $signed({{(EXPW-SGL_EW){1'b0}}, s_exp}) - SBIAS;
      f_o.sig     = {1'b1, s_man, {(DBL_MW-SGL_MW){1'b0}}};
      f_o.mant_nz = |s_man;
      f_o.is_zero = (s_exp == '0) && (s_man == '0);
    end
  end
endmodule

// File: rtl/fp2uint_align.sv
module fp2uint_align
  import fp2uint_pkg::*;
(
  input  logic [SIGW-1:0] sig_i,
  input  logic [SHW-1:0]  shamt_i,
  output logic [RESW-1:0] int_o,
  output logic            rnd_o,
  output logic            sticky_o
);
  // significand sits as a fixed-point value with FRACW fraction bits
  logic [XW-1:0] x;
  logic [YW-1:0] y;

  assign x        = {sig_i, {RESW{1'b0}}};
  assign y        = YW'(x) << shamt_i;
  assign int_o    = y[YW-1 -: RESW];
  assign rnd_o    = y[FRACW-1];
  assign sticky_o = |y[FRACW-2:0];
endmodule

// File: rtl/fp2uint_core.sv
module fp2uint_core
  import fp2uint_pkg::*;
(
  input  logic                   sign_i,
  input  logic signed [EXPW-1:0] uexp_i,
  input  logic                   mant_nz_i,
  input  logic                   is_zero_i,
  input  logic                   wide_i,
  input  rmode_e                 rmode_i,
  input  logic [RESW-1:0]        int_i,
  input  logic                   rnd_i,
  input  logic                   sticky_i,
  output logic [RESW-1:0]        res_o,
  output logic                   inv_o,
  output logic                   inx_o
);
  localparam logic signed [EXPW-1:0] MAXE_W = EXPW'(RESW - 1);
  localparam logic signed [EXPW-1:0] MAXE_N = EXPW'(NARW - 1);
  localparam logic signed [EXPW-1:0] EXP_M1 = -EXPW'(1);

  logic signed [EXPW-1:0] max_e;
  logic [RESW-1:0]        ones;
  logic                   inc;
  logic                   ovf;
  logic [RESW:0]          sum;

  assign max_e = wide_i ? MAXE_W : MAXE_N;
  assign ones  = wide_i ? {RESW{1'b1}} : RESW'({NARW{1'b1}});
  assign inc   = (rnd_i | sticky_i) &
                 ((rmode_i == RM_UP) |
                  ((rmode_i == RM_NEAR) & rnd_i & (sticky_i | int_i[0])));
  assign sum   = {1'b0, int_i} + (RESW+1)'(inc);
  assign ovf   = wide_i ? sum[RESW] : sum[NARW];

  always_comb begin
    res_o = '0;
    inv_o = 1'b0;
    inx_o = 1'b0;
    if (is_zero_i) begin
      res_o = '0;
    end else if (uexp_i > max_e) begin
      inv_o = 1'b1;
      res_o = sign_i ? '0 : ones;
    end else if (!uexp_i[EXPW-1]) begin
      if (sign_i) begin
        inv_o = 1'b1;
      end else if (ovf) begin
        inv_o = 1'b1;
        res_o = ones;
      end else begin
        inx_o = rnd_i | sticky_i;
        res_o = sum[RESW-1:0];
      end
    end else begin
      inx_o = 1'b1;
      unique case (rmode_i)
        RM_UP:   if (!sign_i) res_o = RESW'(1);
        RM_DOWN: if (sign_i) inv_o = 1'b1;
        RM_NEAR: if (uexp_i == EXP_M1 && mant_nz_i) begin
                   if (sign_i) inv_o = 1'b1;
                   else        res_o = RESW'(1);
                 end
        default: ;
      endcase
      if (inv_o) inx_o = 1'b0;
    end
  end

  // R9: invalid never leaves inexact standing
  always_comb a_r9_core_prio: assert (!(inv_o && inx_o));
endmodule

// File: rtl/fp2uint_except.sv
module fp2uint_except
  import fp2uint_pkg::*;
(
  input  logic [RESW-1:0] res_i,
  input  logic            inv_i,
  input  logic            inx_i,
  input  logic            trap_inv_en_i,
  input  logic            trap_inx_en_i,
  output logic [RESW-1:0] res_o,
  output logic            trap_o,
  output exc_e            code_o,
  output logic            flag_inv_o,
  output logic            flag_inx_o
);
  always_comb begin
    res_o      = res_i;
    trap_o     = 1'b0;
    code_o     = EXC_NONE;
    flag_inv_o = 1'b0;
    flag_inx_o = 1'b0;
    if (inv_i) begin
      if (trap_inv_en_i) begin
        trap_o = 1'b1;
        code_o = EXC_INV;
        res_o  = '0;
      end else begin
        flag_inv_o = 1'b1;
      end
    end else if (inx_i) begin
      if (trap_inx_en_i) begin
        trap_o = 1'b1;
        code_o = EXC_INX;
        res_o  = '0;
      end else begin
        flag_inx_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fp2uint_cvt.sv
module fp2uint_cvt
  import fp2uint_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [OPW-1:0]  operand_i,
  input  logic            src_dbl_i,
  input  logic            dst_wide_i,
  input  logic [1:0]      rmode_i,
  input  logic            trap_inv_en_i,
  input  logic            trap_inx_en_i,
  output logic            valid_o,
  output logic [RESW-1:0] result_o,
  output logic            trap_o,
  output logic [1:0]      exc_code_o,
  output logic            flag_inv_o,
  output logic            flag_inx_o
);
  fields_t         f;
  logic [RESW-1:0] int_part;
  logic            rnd, sticky;
  logic [RESW-1:0] core_res, fin_res;
  logic            core_inv, core_inx;
  logic            fin_trap, fin_inv, fin_inx;
  exc_e            fin_code;
  logic            wide_q;

  fp2uint_unpack u_unpack (
    .op_i  (operand_i),
    .dbl_i (src_dbl_i),
    .f_o   (f)
  );

  fp2uint_align u_align (
    .sig_i    (f.sig),
    .shamt_i  (f.uexp[SHW-1:0]),
    .int_o    (int_part),
    .rnd_o    (rnd),
    .sticky_o (sticky)
  );

  fp2uint_core u_core (
    .sign_i    (f.sign),
    .uexp_i    (f.uexp),
    .mant_nz_i (f.mant_nz),
    .is_zero_i (f.is_zero),
    .wide_i    (dst_wide_i),
    .rmode_i   (rmode_e'(rmode_i)),
    .int_i     (int_part),
    .rnd_i     (rnd),
    .sticky_i  (sticky),
    .res_o     (core_res),
    .inv_o     (core_inv),
    .inx_o     (core_inx)
  );

  fp2uint_except u_except (
    .res_i         (core_res),
    .inv_i         (core_inv),
    .inx_i         (core_inx),
    .trap_inv_en_i (trap_inv_en_i),
    .trap_inx_en_i (trap_inx_en_i),
    .res_o         (fin_res),
    .trap_o        (fin_trap),
    .code_o        (fin_code),
    .flag_inv_o    (fin_inv),
    .flag_inx_o    (fin_inx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      result_o   <= '0;
      trap_o     <= 1'b0;
      exc_code_o <= EXC_NONE;
      flag_inv_o <= 1'b0;
      flag_inx_o <= 1'b0;
      wide_q     <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o   <= fin_res;
        trap_o     <= fin_trap;
        exc_code_o <= fin_code;
        flag_inv_o <= fin_inv;
        flag_inx_o <= fin_inx;
        wide_q     <= dst_wide_i;
      end
    end
  end

  a_r1_valid_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r1_idle_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r9_one_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({flag_inv_o, flag_inx_o}));
  a_r10_trap_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (result_o == '0 && !flag_inv_o && !flag_inx_o &&
                (exc_code_o == EXC_INV || exc_code_o == EXC_INX)));
  a_r10_no_code_untrapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |-> exc_code_o == EXC_NONE);
  a_r11_narrow_zext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !wide_q) |-> result_o[RESW-1:NARW] == '0);
  a_r6_inv_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_inv_o |-> (result_o == '0 || result_o == {RESW{1'b1}} ||
                    result_o == RESW'({NARW{1'b1}})));
endmodule

// File: tb/fp2uint_cvt_test.sv
`timescale 1ns/1ps
module fp2uint_cvt_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] operand_i = '0;
  logic        src_dbl_i = 1'b0;
  logic        dst_wide_i = 1'b0;
  logic [1:0]  rmode_i = 2'd0;
  logic        trap_inv_en_i = 1'b0;
  logic        trap_inx_en_i = 1'b0;
  logic        valid_o;
  logic [63:0] result_o;
  logic        trap_o;
  logic [1:0]  exc_code_o;
  logic        flag_inv_o;
  logic        flag_inx_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  localparam logic [63:0] ONES32 = 64'h0000_0000_FFFF_FFFF;
  localparam logic [63:0] ONES64 = 64'hFFFF_FFFF_FFFF_FFFF;

  always #2.5 clk_i = ~clk_i;

  fp2uint_cvt uut (.*);

  task automatic check_out(input string tag, input logic [63:0] er,
                           input logic ei, input logic ex,
                           input logic et, input logic [1:0] ec);
    logic [68:0] got, exp;
    got = {valid_o, trap_o, exc_code_o, flag_inv_o, flag_inx_o, result_o};
    exp = {1'b1, et, ec, ei, ex, er};
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got v/t/c/i/x/res=%h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [63:0] op, input logic dbl, input logic wide,
                       input logic [1:0] rm, input logic ti, input logic tx);
    @(negedge clk_i);
    operand_i = op; src_dbl_i = dbl; dst_wide_i = wide; rmode_i = rm;
    trap_inv_en_i = ti; trap_inx_en_i = tx; valid_i = 1'b1;
    @(posedge clk_i);
    #1;
    valid_i = 1'b0;
  endtask

  task automatic run(input string tag, input logic [63:0] op, input logic dbl,
                     input logic wide, input logic [1:0] rm, input logic ti,
                     input logic tx, input logic [63:0] er, input logic ei,
                     input logic ex, input logic et, input logic [1:0] ec);
    apply(op, dbl, wide, rm, ti, tx);
    check_out(tag, er, ei, ex, et, ec);
  endtask

  task automatic test_reset();
    checks++;
    if ({valid_o, trap_o, exc_code_o, flag_inv_o, flag_inx_o, result_o} !== '0) begin
      failures++;
      $display("FAIL R1 reset: got %h expected 0", result_o);
    end
  endtask

  task automatic test_timing();
    run("R1 issue", 64'h0000_0000_4040_0000, 0, 0, 2'd1, 0, 0, 64'd3, 0, 0, 0, 2'd0);
    @(posedge clk_i); #1;
    checks++;
    if (valid_o !== 1'b0) begin
      failures++;
      $display("FAIL R1 idle: got valid_o=%b expected 0", valid_o);
    end
  endtask

  task automatic test_exact();
    run("R2 R11 single 5.0 upper ignored", 64'hDEAD_BEEF_40A0_0000, 0, 0, 2'd0, 0, 0, 64'd5, 0, 0, 0, 2'd0);
    run("R2 double 2^63 wide", 64'h43E0_0000_0000_0000, 1, 1, 2'd0, 0, 0, 64'h8000_0000_0000_0000, 0, 0, 0, 2'd0);
    run("R11 single 2^32 wide", 64'h0000_0000_4F80_0000, 0, 1, 2'd1, 0, 0, 64'h1_0000_0000, 0, 0, 0, 2'd0);
  endtask

  task automatic test_rounding();
    run("R3 2.5 near", 64'h4020_0000, 0, 0, 2'd0, 0, 0, 64'd2, 0, 1, 0, 2'd0);
    run("R3 2.5 zero", 64'h4020_0000, 0, 0, 2'd1, 0, 0, 64'd2, 0, 1, 0, 2'd0);
    run("R3 2.5 up",   64'h4020_0000, 0, 0, 2'd2, 0, 0, 64'd3, 0, 1, 0, 2'd0);
    run("R3 2.5 down", 64'h4020_0000, 0, 0, 2'd3, 0, 0, 64'd2, 0, 1, 0, 2'd0);
    run("R3 3.5 near", 64'h4060_0000, 0, 0, 2'd0, 0, 0, 64'd4, 0, 1, 0, 2'd0);
    run("R3 2.75 near", 64'h4030_0000, 0, 0, 2'd0, 0, 0, 64'd3, 0, 1, 0, 2'd0);
    run("R3 double 1.5 near wide", 64'h3FF8_0000_0000_0000, 1, 1, 2'd0, 0, 0, 64'd2, 0, 1, 0, 2'd0);
  endtask

  task automatic test_small();
    run("R4 0.75 near", 64'h3F40_0000, 0, 0, 2'd0, 0, 0, 64'd1, 0, 1, 0, 2'd0);
    run("R4 0.75 zero", 64'h3F40_0000, 0, 0, 2'd1, 0, 0, 64'd0, 0, 1, 0, 2'd0);
    run("R4 0.75 up",   64'h3F40_0000, 0, 0, 2'd2, 0, 0, 64'd1, 0, 1, 0, 2'd0);
    run("R4 0.75 down", 64'h3F40_0000, 0, 0, 2'd3, 0, 0, 64'd0, 0, 1, 0, 2'd0);
    run("R4 0.5 near",  64'h3F00_0000, 0, 0, 2'd0, 0, 0, 64'd0, 0, 1, 0, 2'd0);
    run("R4 0.25 up",   64'h3E80_0000, 0, 1, 2'd2, 0, 0, 64'd1, 0, 1, 0, 2'd0);
  endtask

  task automatic test_negative();
    run("R5 -0.75 near", 64'hBF40_0000, 0, 0, 2'd0, 0, 0, 64'd0, 1, 0, 0, 2'd0);
    run("R5 -0.75 down", 64'hBF40_0000, 0, 0, 2'd3, 0, 0, 64'd0, 1, 0, 0, 2'd0);
    run("R5 -0.75 zero", 64'hBF40_0000, 0, 0, 2'd1, 0, 0, 64'd0, 0, 1, 0, 2'd0);
    run("R5 -0.75 up",   64'hBF40_0000, 0, 0, 2'd2, 0, 0, 64'd0, 0, 1, 0, 2'd0);
    run("R5 -0.5 near",  64'hBF00_0000, 0, 0, 2'd0, 0, 0, 64'd0, 0, 1, 0, 2'd0);
    run("R5 -2.0 zero",  64'hC000_0000, 0, 0, 2'd1, 0, 0, 64'd0, 1, 0, 0, 2'd0);
  endtask

  task automatic test_saturate();
    run("R6 single 2^32 narrow", 64'h4F80_0000, 0, 0, 2'd1, 0, 0, ONES32, 1, 0, 0, 2'd0);
    run("R6 single -2^40 narrow", 64'hD380_0000, 0, 0, 2'd1, 0, 0, 64'd0, 1, 0, 0, 2'd0);
    run("R6 double 2^100 wide", 64'h4630_0000_0000_0000, 1, 1, 2'd0, 0, 0, ONES64, 1, 0, 0, 2'd0);
  endtask

  task automatic test_overflow();
    run("R7 2^32-0.5 up narrow",   64'h41EF_FFFF_FFF0_0000, 1, 0, 2'd2, 0, 0, ONES32, 1, 0, 0, 2'd0);
    run("R7 2^32-0.5 near narrow", 64'h41EF_FFFF_FFF0_0000, 1, 0, 2'd0, 0, 0, ONES32, 1, 0, 0, 2'd0);
    run("R7 2^32-0.5 zero narrow", 64'h41EF_FFFF_FFF0_0000, 1, 0, 2'd1, 0, 0, ONES32, 0, 1, 0, 2'd0);
    run("R7 2^32-0.5 up wide",     64'h41EF_FFFF_FFF0_0000, 1, 1, 2'd2, 0, 0, 64'h1_0000_0000, 0, 1, 0, 2'd0);
  endtask

  task automatic test_zero();
    run("R8 +0 up",   64'h0000_0000, 0, 0, 2'd2, 0, 0, 64'd0, 0, 0, 0, 2'd0);
    run("R8 -0 down", 64'h8000_0000, 0, 0, 2'd3, 0, 0, 64'd0, 0, 0, 0, 2'd0);
    run("R8 double -0 near", 64'h8000_0000_0000_0000, 1, 1, 2'd0, 1, 1, 64'd0, 0, 0, 0, 2'd0);
  endtask

  task automatic test_traps();
    run("R9 -0.75 near inx trap only", 64'hBF40_0000, 0, 0, 2'd0, 0, 1, 64'd0, 1, 0, 0, 2'd0);
    run("R10 -0.75 near inv trap", 64'hBF40_0000, 0, 0, 2'd0, 1, 1, 64'd0, 0, 0, 1, 2'd1);
    run("R10 2.5 near inx trap",   64'h4020_0000, 0, 0, 2'd0, 1, 1, 64'd0, 0, 0, 1, 2'd2);
    run("R10 2^100 inv trap",      64'h4630_0000_0000_0000, 1, 1, 2'd0, 1, 0, 64'd0, 0, 0, 1, 2'd1);
    run("R10 5.0 exact traps on",  64'h40A0_0000, 0, 0, 2'd0, 1, 1, 64'd5, 0, 0, 0, 2'd0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1;
    test_reset();
    #12;
    rst_ni = 1'b1;
    test_timing();
    test_exact();
    test_rounding();
    test_small();
    test_negative();
    test_saturate();
    test_overflow();
    test_zero();
    test_traps();
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule